// File: doc/BRIEF.md
# Dual-Bank Burst Cache Sequencer

This block drives the strobes of a pipelined-burst SRAM second-level cache during four-beat line fills. A host-side agent presents line addresses with a valid/ready handshake. For each accepted request the sequencer drives the SRAM chip enable and the controller address strobe. It also drives the bank-select address bit, the latched line address, a beat-valid pulse and a beat index. The SRAM storage, tag lookup and hit/miss decisions sit elsewhere.

The cache is built either from one bank or from two banks. When there are two banks, a single high address bit picks the bank and feeds the secondary chip-enable input of the SRAMs. A burst started from idle has a three-clock lead-off and then three single-clock beats. A request accepted on the final beat of the running burst follows at once, with no lead-off. There is one exception. In two-bank mode, a follow-on burst that flips the bank bit gets one wait clock. During that clock the primary chip enable is negated, so the outgoing bank can finish its last beat before the new address is strobed.

Top module: `dual_bank_burst_seq`

## Requirements
- R1: While reset (active low, synchronous) is held, and on the first clock after it is released, chip enable and address strobe are high, beat valid is low and req_ready is high.
- R2: A request accepted while idle gives a cycle with address strobe and chip enable low. Beat 0 follows LEAD_CYC-1 cycles later, and beat indices 0,1,2,3 then come on consecutive cycles (3-1-1-1 with the default LEAD_CYC=3).
- R3: req_ready is high only while idle or during the final beat (index 3) of a burst. A request held valid at any other time is not taken.
- R4: A request accepted on the final beat that keeps the same bank-bit value starts beat 0 in the very next cycle, with address strobe low in that cycle (1-1-1-1).
- R5: In two-bank mode (cache_mode == 2'b11), a request accepted on the final beat whose bank bit differs from the current one gives one wait cycle. In that cycle chip enable and address strobe are high and beat valid is low. Beat 0 then follows with address strobe low (2-1-1-1).
- R6: With any cache_mode other than 2'b11, a follow-on burst never gets a wait cycle, even when the bank bit changes.
- R7: sram_bank equals bit BANK_BIT (default 18) of the most recently accepted request address. It takes that value from the cycle after acceptance, wait cycle included.
- R8: Address strobe is low exactly once per burst, and only while chip enable is low. Chip enable is low in every lead-off and beat cycle.
- R9: sram_addr equals the accepted request address for the whole burst.
- R10: After the final beat, if no request was accepted, the sequencer returns to idle with chip enable high and beat valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cache_mode | input | 2 | Bank configuration field; 2'b11 selects two banks |
| req_valid | input | 1 | Line-fill request present |
| req_ready | output | 1 | Request accepted on this clock when valid |
| req_addr | input | ADDR_W | Line-fill address |
| sram_ce_n | output | 1 | SRAM primary chip enable, active low |
| sram_adsc_n | output | 1 | Controller address strobe, active low |
| sram_bank | output | 1 | Bank-select address bit to SRAM secondary enable |
| sram_addr | output | ADDR_W | Latched burst address |
| beat_valid | output | 1 | High in each data-beat cycle |
| beat_idx | output | BEAT_W | Index of the current beat |

## Verification
The bench builds the block with its defaults: 32-bit addresses, the bank bit at position 18, a three-clock lead-off and four beats. With these values, a jump between 0x0000_xxxx and 0x0004_xxxx addresses flips the bank while keeping the lower line bits plausible. The bench chains such addresses back to back under all four mode field values. This reaches the 3-1-1-1 start, the 1-1-1-1 same-bank chain, the 2-1-1-1 crossing, and bank flips that must not stall in single-bank mode.

// File: rtl/bsq_pkg.sv
// Shared types for the burst cache sequencer.
package bsq_pkg;
    // Sequencer phases: idle, lead-off, data beats, bank-crossing wait.
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LEAD = 2'd1,
        SQ_BEAT = 2'd2,
        SQ_GAP  = 2'd3
    } sq_state_t;
endpackage

// File: rtl/bsq_mode_decode.sv
// Decodes the bank configuration field and detects a bank crossing.
// Assumes cur_bank holds the bank bit of the burst now running.
module bsq_mode_decode #(
    parameter int ADDR_W   = 32,
    parameter int BANK_BIT = 18
) (
    input  logic [1:0]        cache_mode,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cur_bank,
    output logic              dual_mode,
    output logic              new_bank,
    output logic              bank_cross
);
    // Two-bank operation only when both field bits are set; crossing needs it.
    always_comb begin
        dual_mode  = (cache_mode == 2'b11);
        new_bank   = req_addr[BANK_BIT];
        bank_cross = dual_mode && (new_bank != cur_bank);
    end
endmodule

// File: rtl/bsq_lead_timer.sv
// Lead-off timer: after a start pulse, raises expire in the last lead cycle.
// Assumes LEAD_CYC >= 2 (strobe cycle plus at least one more before beat 0).
module bsq_lead_timer #(
    parameter int LEAD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int LC_W = (LEAD_CYC > 2) ? $clog2(LEAD_CYC) : 1;

    logic [LC_W-1:0] cnt_q;

    // Load the remaining lead count on start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= LC_W'(LEAD_CYC - 2);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Expiry is flagged while the count sits at zero.
    assign expire = (cnt_q == '0);

    p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == LC_W'(LEAD_CYC - 2)));
endmodule

// File: rtl/dual_bank_burst_seq.sv
// Burst cache sequencer: drives SRAM strobes for four-beat line fills,
// chaining bursts back to back and inserting one wait clock on a bank
// crossing in two-bank mode. Assumes the requester holds req_addr stable
// while req_valid is high.
module dual_bank_burst_seq
    import bsq_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int BANK_BIT = 18,
    parameter int LEAD_CYC = 3,
    parameter int BEATS    = 4,
    localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cache_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              sram_ce_n,
    output logic              sram_adsc_n,
    output logic              sram_bank,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              beat_valid,
    output logic [BEAT_W-1:0] beat_idx
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    sq_state_t         st_q;
    logic [BEAT_W-1:0] beat_q;
    logic              strobe_q;
    logic              bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic              dual_mode, new_bank, bank_cross;
    logic              lead_start, lead_expire, accept, on_last;

    bsq_mode_decode #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT)) i_decode (
        .cache_mode (cache_mode),
        .req_addr   (req_addr),
        .cur_bank   (bank_q),
        .dual_mode  (dual_mode),
        .new_bank   (new_bank),
        .bank_cross (bank_cross)
    );

    bsq_lead_timer #(.LEAD_CYC(LEAD_CYC)) i_lead (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (lead_start),
        .expire (lead_expire)
    );

    // Handshake: open while idle or on the last beat of a burst.
    always_comb begin
        on_last    = (st_q == SQ_BEAT) && (beat_q == LAST_BEAT);
        req_ready  = (st_q == SQ_IDLE) || on_last;
        accept     = req_valid && req_ready;
        lead_start = accept && (st_q == SQ_IDLE);
    end

    // Phase sequencing, beat counting and address/bank capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= SQ_IDLE;
            beat_q   <= '0;
            strobe_q <= 1'b0;
            bank_q   <= 1'b0;
            addr_q   <= '0;
        end else begin
            strobe_q <= 1'b0;
            unique case (st_q)
                SQ_IDLE: if (accept) begin
                    st_q     <= SQ_LEAD;
                    strobe_q <= 1'b1;
                    bank_q   <= new_bank;
                    addr_q   <= req_addr;
                end
                SQ_LEAD: if (lead_expire) begin
                    st_q   <= SQ_BEAT;
                    beat_q <= '0;
                end
                SQ_BEAT: begin
                    if (!on_last) begin
                        beat_q <= beat_q + 1'b1;
                    end else if (accept) begin
                        bank_q <= new_bank;
                        addr_q <= req_addr;
                        beat_q <= '0;
                        if (bank_cross) begin
                            st_q <= SQ_GAP;
                        end else begin
                            st_q     <= SQ_BEAT;
                            strobe_q <= 1'b1;
                        end
                    end else begin
                        st_q <= SQ_IDLE;
                    end
                end
                SQ_GAP: begin
                    st_q     <= SQ_BEAT;
                    strobe_q <= 1'b1;
                    beat_q   <= '0;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Output decode from registered state.
    always_comb begin
        sram_ce_n   = !((st_q == SQ_LEAD) || (st_q == SQ_BEAT));
        sram_adsc_n = !strobe_q;
        sram_bank   = bank_q;
        sram_addr   = addr_q;
        beat_valid  = (st_q == SQ_BEAT);
        beat_idx    = beat_q;
    end

    // Requirement checks beside the sequencing logic.
    p_ready_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (sram_ce_n || (beat_valid && beat_idx == LAST_BEAT)));

    p_beat_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_idx != LAST_BEAT) |=>
            (beat_valid && beat_idx == $past(beat_idx) + 1'b1));

    p_cross_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_idx == LAST_BEAT && req_valid && cache_mode == 2'b11
            && req_addr[BANK_BIT] != sram_bank)
        |=> (sram_ce_n && sram_adsc_n && !beat_valid));

    p_gap_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_ce_n && !req_ready) |=> (!sram_adsc_n && beat_valid && beat_idx == '0));

    p_no_gap_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_idx == LAST_BEAT && req_valid && !dual_mode)
        |=> (beat_valid && beat_idx == '0 && !sram_adsc_n));

    p_strobe_under_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_adsc_n |-> !sram_ce_n);

    p_hold_in_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_idx != LAST_BEAT) |=> ($stable(sram_addr) && $stable(sram_bank)));
endmodule

// File: tb/test_dual_bank_burst_seq.sv
// Bench: a queue-based reference model predicts every cycle's outputs.
module test_dual_bank_burst_seq;
    localparam int CLK_P    = 10;
    localparam int ADDR_W   = 32;
    localparam int BANK_BIT = 18;
    localparam int LEAD_CYC = 3;
    localparam int BEATS    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cache_mode = 2'b00;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              sram_ce_n, sram_adsc_n, sram_bank, beat_valid;
    logic [ADDR_W-1:0] sram_addr;
    logic [1:0]        beat_idx;

    int n_chk = 0;
    int n_fail = 0;

    dual_bank_burst_seq #(.ADDR_W(ADDR_W), .BANK_BIT(BANK_BIT),
                          .LEAD_CYC(LEAD_CYC), .BEATS(BEATS)) i_dual_bank_burst_seq (
        .clk(clk), .rst_n(rst_n), .cache_mode(cache_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .sram_ce_n(sram_ce_n), .sram_adsc_n(sram_adsc_n), .sram_bank(sram_bank),
        .sram_addr(sram_addr), .beat_valid(beat_valid), .beat_idx(beat_idx)
    );

    always #(CLK_P/2) clk = ~clk;

    // One expected cycle; tag is the requirement number the timing belongs to.
    typedef struct {
        logic        ce_n;
        logic        adsc_n;
        logic        beat;
        int          idx;
        logic        bank;
        logic [31:0] addr;
        int          tag;
    } exp_t;

    exp_t        q[$];
    logic [31:0] pend[$];
    logic        m_bank = 1'b0;

    task automatic chk(input logic ok, input int req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic ce, input logic ad, input logic bt, input int ix,
                        input logic bk, input logic [31:0] a, input int tg);
        exp_t e;
        e.ce_n = ce; e.adsc_n = ad; e.beat = bt; e.idx = ix;
        e.bank = bk; e.addr = a; e.tag = tg;
        q.push_back(e);
    endtask

    // One clock: drive, compare with the model, advance the model.
    task automatic step();
        logic exp_ready, acc, nb, idle_before;
        exp_t e;
        @(negedge clk);
        req_valid = (pend.size() > 0);
        req_addr  = req_valid ? pend[0] : '0;
        #1;
        exp_ready = (q.size() == 0) || (q.size() == 1 && q[0].beat);
        chk(req_ready == exp_ready, 3, "req_ready", req_ready, exp_ready);   // R3
        if (q.size() == 0) begin
            // R10: idle between bursts
            chk(sram_ce_n == 1'b1, 10, "ce_n idle", sram_ce_n, 1);
            chk(sram_adsc_n == 1'b1, 8, "adsc_n idle", sram_adsc_n, 1);
            chk(beat_valid == 1'b0, 10, "beat_valid idle", beat_valid, 0);
        end else begin
            e = q[0];
            chk(sram_ce_n == e.ce_n, 8, "ce_n", sram_ce_n, e.ce_n);          // R8
            chk(sram_adsc_n == e.adsc_n, 8, "adsc_n", sram_adsc_n, e.adsc_n);
            chk(beat_valid == e.beat, e.tag, "beat_valid", beat_valid, e.beat);
            if (e.beat)
                chk(int'(beat_idx) == e.idx, e.tag, "beat_idx", beat_idx, e.idx);
            chk(sram_bank == e.bank, 7, "bank", sram_bank, e.bank);          // R7
            if (!e.ce_n)
                chk(sram_addr == e.addr, 9, "addr", sram_addr, e.addr);      // R9
        end
        acc = req_valid && exp_ready;
        idle_before = (q.size() == 0);
        if (q.size() > 0) void'(q.pop_front());
        if (acc) begin
            nb = req_addr[BANK_BIT];
            if (idle_before) begin
                // R2: strobe cycle, remaining lead-off, then four beats
                push(0, 0, 0, 0, nb, req_addr, 2);
                for (int i = 0; i < LEAD_CYC - 2; i++) push(0, 1, 0, 0, nb, req_addr, 2);
                for (int b = 0; b < BEATS; b++) push(0, 1, 1, b, nb, req_addr, 2);
            end else if (cache_mode == 2'b11 && nb != m_bank) begin
                // R5: one wait with both strobes high, then beats
                push(1, 1, 0, 0, nb, req_addr, 5);
                for (int b = 0; b < BEATS; b++) push(0, (b != 0), 1, b, nb, req_addr, 5);
            end else begin
                // R4 same bank, R6 crossing ignored in single-bank mode
                for (int b = 0; b < BEATS; b++)
                    push(0, (b != 0), 1, b, nb, req_addr, (nb != m_bank) ? 6 : 4);
            end
            m_bank = nb;
            void'(pend.pop_front());
        end
    endtask

    task automatic drain();
        int guard = 0;
        while ((pend.size() > 0 || q.size() > 0) && guard < 1000) begin
            step();
            guard++;
        end
        step();
        step();
    endtask

    // Watchdog: a hung run is one failed check and still reports.
    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1: reset with a request pending
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = 32'h0004_0000;
        @(negedge clk);
        #1;
        chk(sram_ce_n == 1'b1, 1, "ce_n in reset", sram_ce_n, 1);
        chk(sram_adsc_n == 1'b1, 1, "adsc_n in reset", sram_adsc_n, 1);
        chk(beat_valid == 1'b0, 1, "beat_valid in reset", beat_valid, 0);
        chk(req_ready == 1'b1, 1, "req_ready in reset", req_ready, 1);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(sram_ce_n == 1'b1, 1, "ce_n after reset", sram_ce_n, 1);
        chk(beat_valid == 1'b0, 1, "beat_valid after reset", beat_valid, 0);

        // Single request from idle: 3-1-1-1 then idle (R2, R10)
        cache_mode = 2'b00;
        pend.push_back(32'h0000_1000);
        drain();

        // Single-bank chain with bank-bit flips: no wait (R4, R6)
        pend.push_back(32'h0000_1000); pend.push_back(32'h0000_1020);
        pend.push_back(32'h0004_2000); pend.push_back(32'h0000_1040);
        drain();

        // Two-bank chain: same bank, then crossings both ways (R4, R5)
        cache_mode = 2'b11;
        pend.push_back(32'h0000_1000); pend.push_back(32'h0000_1020);
        pend.push_back(32'h0004_2000); pend.push_back(32'h0004_2020);
        pend.push_back(32'h0000_1060);
        drain();

        // Partial field values stay single-bank (R6)
        cache_mode = 2'b01;
        pend.push_back(32'h0000_2000); pend.push_back(32'h0004_3000);
        drain();
        cache_mode = 2'b10;
        pend.push_back(32'h0004_4000); pend.push_back(32'h0000_4000);
        drain();

        // Two-bank, start in bank 1, cross, then a late request after idle (R5, R3)
        cache_mode = 2'b11;
        pend.push_back(32'h0004_8000); pend.push_back(32'h0000_8000);
        drain();
        pend.push_back(32'h0004_9000);
        step(); step();
        pend.push_back(32'h0004_9040);
        drain();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule